// File: doc/BRIEF.md
# Eight-Bit GPIO Port Controller

This block is the register and pad-control core of one general-purpose I/O port. It has eight bit positions, of which seven connect to physical pins. Software sets, through a small register interface, a direction register and an output-data register. From these the block derives three controls for each pin: output enable, output value and weak pull-up enable. These go to a pad model. The levels on the pins come back through a two-stage synchronizer into an input register that software can read.

The output-data bit has two jobs. On an output pin it sets the level that is driven. On an input pin it switches the weak pull-up on or off. The two top pins are open-drain. They can only pull low, they have no pull-up, and a 1 on either of them releases the pin to an external resistor. Bit position 5 has no pin: it holds a constant, ignores writes and never drives its pad.

Registers are written with a one-cycle strobe. Reads are combinational, through a two-bit select.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads 0x00, so every pin is an input.
- R2: After reset the output-data register reads 0xFF, so the weak pull-up is on for every push-pull input pin.
- R3: Bit 5 is fixed: it reads 0 in the direction register, 1 in the output-data register and 0 in the input register, whatever is written or driven. Its pad_oe, pad_out and pad_pu are always 0.
- R4: When wr_en is high at a rising clock edge, the register chosen by addr takes wdata. The codes are addr 0 for direction, 1 for output data, 2 for input and 3 for unmapped. Each bit position is written independently.
- R5: On a push-pull pin (bits 0 to 4) whose direction bit is 1, pad_oe is 1, pad_out equals the output-data bit and pad_pu is 0.
- R6: On a push-pull pin whose direction bit is 0, pad_oe is 0 and pad_out is 0. pad_pu equals the output-data bit, so 1 turns the pull-up on and 0 leaves the pin floating.
- R7: On open-drain pins 6 and 7, pad_out and pad_pu are always 0. pad_oe is 1 only when the direction bit is 1 and the output-data bit is 0.
- R8: A level on pin_in becomes readable at addr 2 exactly two rising edges after it is applied. Until then the register still reads the earlier level.
- R9: Writes to addr 2 or addr 3 change no register, and addr 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels seen at the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
Every one of the 256 direction values is paired with several output-data values: equal to it, its complement, all zeros, all ones and a checkerboard. Together these cover all four direction/data combinations on every pin, including the open-drain pins and the pinless bit. They separate push-pull drive, pull-up control and open-drain release. All 256 pin_in patterns are read both one edge and two edges after they are applied, which pins down the synchronizer latency. Writes to the input and unmapped addresses show that no register is disturbed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      SEL_DIR  = 2'd0,
      SEL_OUT  = 2'd1,
      SEL_IN   = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
   parameter int unsigned          NBITS       = 8,
   parameter logic [NBITS-1:0]     ABSENT_MASK = 8'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [NBITS-1:0] wdata,
   input  logic [NBITS-1:0] in_sync,
   output logic [NBITS-1:0] dir_q,
   output logic [NBITS-1:0] odat_q,
   output logic [NBITS-1:0] rdata
);
   import gpio_pkg::*;

   localparam logic [NBITS-1:0] IMPL_MASK = ~ABSENT_MASK;
   localparam logic [NBITS-1:0] DIR_RST   = '0;
   localparam logic [NBITS-1:0] ODAT_RST  = '1;

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RST;
         odat_q <= ODAT_RST;
      end else if (wr_en) begin
         if (sel == SEL_DIR) dir_q  <= wdata & IMPL_MASK;
         if (sel == SEL_OUT) odat_q <= wdata | ABSENT_MASK;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_DIR:  rdata = dir_q & IMPL_MASK;
         SEL_OUT:  rdata = odat_q | ABSENT_MASK;
         SEL_IN:   rdata = in_sync & IMPL_MASK;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NBITS  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] d,
   output logic [NBITS-1:0] q
);
   logic [NBITS-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int unsigned      NBITS       = 8,
   parameter logic [NBITS-1:0] ABSENT_MASK = 8'h20,
   parameter logic [NBITS-1:0] ODRAIN_MASK = 8'hC0
) (
   input  logic [NBITS-1:0] dir_q,
   input  logic [NBITS-1:0] odat_q,
   output logic [NBITS-1:0] pad_oe,
   output logic [NBITS-1:0] pad_out,
   output logic [NBITS-1:0] pad_pu
);
   for (genvar i = 0; i < NBITS; i++) begin : g_pin
      if (ABSENT_MASK[i]) begin : g_absent
         assign pad_oe[i]  = 1'b0;
         assign pad_out[i] = 1'b0;
         assign pad_pu[i]  = 1'b0;
      end else if (ODRAIN_MASK[i]) begin : g_odrain
         assign pad_oe[i]  = dir_q[i] & ~odat_q[i];
         assign pad_out[i] = 1'b0;
         assign pad_pu[i]  = 1'b0;
      end else begin : g_pushpull
         assign pad_oe[i]  = dir_q[i];
         assign pad_out[i] = dir_q[i] & odat_q[i];
         assign pad_pu[i]  = ~dir_q[i] & odat_q[i];
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int unsigned      NBITS       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [NBITS-1:0] ABSENT_MASK = 8'h20,
   parameter logic [NBITS-1:0] ODRAIN_MASK = 8'hC0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [NBITS-1:0] wdata,
   output logic [NBITS-1:0] rdata,
   input  logic [NBITS-1:0] pin_in,
   output logic [NBITS-1:0] pad_oe,
   output logic [NBITS-1:0] pad_out,
   output logic [NBITS-1:0] pad_pu
);
   if (NBITS < 1 || NBITS > 32) begin : g_bad_width
      $error("gpio_port_ctrl: NBITS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
   end
   if ((ABSENT_MASK & ODRAIN_MASK) != '0) begin : g_bad_mask
      $error("gpio_port_ctrl: a bit cannot be both absent and open-drain");
   end

   logic [NBITS-1:0] dir_q, odat_q, in_sync;

   gpio_in_sync #(.NBITS(NBITS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
   );

   gpio_regfile #(.NBITS(NBITS), .ABSENT_MASK(ABSENT_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .in_sync(in_sync), .dir_q(dir_q), .odat_q(odat_q), .rdata(rdata)
   );

   gpio_pad_ctl #(.NBITS(NBITS), .ABSENT_MASK(ABSENT_MASK),
                  .ODRAIN_MASK(ODRAIN_MASK)) u_pads (
      .dir_q(dir_q), .odat_q(odat_q),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned      NBITS       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [NBITS-1:0] ABSENT_MASK = 8'h20,
   parameter logic [NBITS-1:0] ODRAIN_MASK = 8'hC0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [NBITS-1:0] wdata,
   input logic [NBITS-1:0] rdata,
   input logic [NBITS-1:0] pin_in,
   input logic [NBITS-1:0] pad_oe,
   input logic [NBITS-1:0] pad_out,
   input logic [NBITS-1:0] pad_pu
);
   localparam logic [NBITS-1:0] PP_MASK = ~(ABSENT_MASK | ODRAIN_MASK);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out | pad_pu) & ABSENT_MASK) == '0); // R3

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out | pad_pu) & ODRAIN_MASK) == '0); // R7

   AST_PU_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0); // R6

   AST_DIR_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0) |=> ((pad_oe & PP_MASK) == ($past(wdata) & PP_MASK))); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> (rdata == '0)); // R9

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_STAGES == 2 && since_rst >= 2'd2 && addr == 2'd2)
         |-> (rdata == ($past(pin_in, 2) & ~ABSENT_MASK))); // R8
endmodule

bind gpio_port_ctrl gpio_port_chk #(
   .NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES),
   .ABSENT_MASK(ABSENT_MASK), .ODRAIN_MASK(ODRAIN_MASK)
) u_chk (.*);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pad_oe, pad_out, pad_pu;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_port_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pu(pad_pu)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      addr = a;
      #0.5;
      v = rdata;
   endtask

   // Expected pad controls, bit by bit from R3, R5, R6, R7
   task automatic expect_pads(input logic [7:0] d, input logic [7:0] o,
                              output logic [7:0] eoe, output logic [7:0] eout,
                              output logic [7:0] epu);
      for (int i = 0; i < 8; i++) begin
         if (i == 5) begin
            eoe[i] = 0; eout[i] = 0; epu[i] = 0;
         end else if (i >= 6) begin
            eoe[i] = d[i] && !o[i]; eout[i] = 0; epu[i] = 0;
         end else begin
            eoe[i] = d[i]; eout[i] = d[i] ? o[i] : 1'b0; epu[i] = d[i] ? 1'b0 : o[i];
         end
      end
   endtask

   initial begin
      logic [7:0] v, eoe, eout, epu, dr, od, prev;
      logic [7:0] opat [5];
      repeat (3) @(negedge clk);
      // R1 R2 reset values and reset pad state
      rd(2'd0, v); chk("R1", v, 8'h00);
      rd(2'd1, v); chk("R2", v, 8'hFF);
      expect_pads(8'h00, 8'hFF, eoe, eout, epu);
      chk("R6", pad_pu, epu); chk("R6", pad_oe, eoe);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, v); chk("R1", v, 8'h00);
      rd(2'd1, v); chk("R2", v, 8'hFF);

      // Sweep every direction value against several data patterns
      for (int d = 0; d < 256; d++) begin
         opat[0] = 8'(d); opat[1] = ~8'(d); opat[2] = 8'h00;
         opat[3] = 8'hFF; opat[4] = 8'h5A;
         for (int k = 0; k < 5; k++) begin
            wr(2'd0, 8'(d));
            wr(2'd1, opat[k]);
            dr = 8'(d) & 8'hDF;
            od = opat[k] | 8'h20;
            rd(2'd0, v); chk("R4", v, dr);
            rd(2'd1, v); chk("R4", v, od);
            chk("R3", v & 8'h20, 8'h20);
            expect_pads(dr, od, eoe, eout, epu);
            chk("R5", pad_oe & 8'h1F, eoe & 8'h1F);
            chk("R5", pad_out & 8'h1F, eout & 8'h1F);
            chk("R6", pad_pu & 8'h1F, epu & 8'h1F);
            chk("R7", pad_oe & 8'hC0, eoe & 8'hC0);
            chk("R7", (pad_out | pad_pu) & 8'hC0, 8'h00);
            chk("R3", (pad_oe | pad_out | pad_pu) & 8'h20, 8'h00);
         end
      end

      // R9: writes to input and unmapped addresses leave registers intact
      wr(2'd0, 8'h9C); wr(2'd1, 8'h41);
      wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
      rd(2'd0, v); chk("R9", v, 8'h9C);
      rd(2'd1, v); chk("R9", v, 8'h61);
      rd(2'd3, v); chk("R9", v, 8'h00);

      // R8: input latency sweep over every pin pattern
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      prev = 8'h00;
      for (int p = 0; p < 256; p++) begin
         pin_in = 8'(p);
         @(negedge clk);
         rd(2'd2, v); chk("R8", v, prev & 8'hDF);
         @(negedge clk);
         rd(2'd2, v); chk("R8", v, 8'(p) & 8'hDF);
         chk("R3", v & 8'h20, 8'h00);
         prev = 8'(p);
      end
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R9", v, 8'hDF);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule